// File: doc/BRIEF.md
# Set-Associative Write-Back Data Cache

This block is a data cache that sits between a processor load/store port and a slower line-wide memory. Each word address is split into a line offset, a set index and a tag. The index picks one set, and every way of that set is compared against the tag in the same cycle. A matching valid way is a hit. A load hit returns its word in the cycle it is presented. A store hit first confirms the match, and only in the following cycle writes the word into the line and marks the line modified.

On a miss the block picks a way to replace. A way that holds no valid line is taken first. If every way is valid, the way touched longest ago is taken. If that line holds modified data, it is sent to memory before the new line is read in. The new line is then installed and the original access is replayed against it. A store that misses therefore also brings its line into the cache before writing it.

The processor must hold its request, address, direction and write data steady while the stall output is high. An access completes at the clock edge where the request is high and the stall is low.

Top module: `wbc_top`

## Requirements
- R1: After reset every line is invalid, no memory request is raised, and the stall output is low while no access is requested.
- R2: A load whose tag matches a valid way in the indexed set completes with zero stall cycles and returns that line's word at the given offset, with no memory traffic.
- R3: A store that hits stalls for exactly one cycle, then writes the word into the matching line and marks it modified, with no memory traffic.
- R4: On a miss, when the set holds an invalid way, the lowest-numbered invalid way is filled, so that no valid line of the set is lost.
- R5: On a miss in a full set, the way least recently touched is replaced. A way counts as touched on every hit and every fill; with 2 ways one bit per set tracks this, and with 4 ways a full age order is kept per set.
- R6: A replaced line that is modified is written to memory, at its own line address and with its latest contents, and this write completes before the refill read is issued.
- R7: A replaced line that is not modified causes no memory write; the miss costs only one line read.
- R8: A store that misses reads its line from memory first, then merges the store into it. The line is left modified, so a later replacement writes it back.
- R9: From miss detection until the replayed access, stall stays high. A memory request holds its address and direction until the memory acknowledges it.
- R10: Every load returns the value of the most recent store to that word address, or the memory's initial value if there was none, across any number of replacements.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cpu_req | input | 1 | Access requested |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word address: tag, then set index, then word offset (offset in the low bits) |
| cpu_wdata | input | DATA_W | Store data |
| cpu_rdata | output | DATA_W | Load data, valid in the completing cycle |
| cpu_stall | output | 1 | Access not completing this cycle; inputs must be held |
| mem_req | output | 1 | Memory line transfer requested |
| mem_we | output | 1 | 1 = line write-back, 0 = line read |
| mem_addr | output | ADDR_W-log2(WORDS) | Line address (tag and set index) |
| mem_wdata | output | WORDS*DATA_W | Line written back; word k at bits k*DATA_W upward |
| mem_rdata | input | WORDS*DATA_W | Line returned by memory, same layout |
| mem_ack | input | 1 | One-cycle acknowledge that completes the memory request |

## Verification
The bench builds the block with 4 ways, 8 sets, 4 words per line, a 10-bit word address and 32-bit data. With these values the per-set age ordering is covered, rather than the single bit used for 2 ways. The address pool holds six tags per set, which is more than the ways, so random traffic keeps forcing replacements of both clean and modified lines. A bench model of tags, validity, modified bits and ages predicts hit or miss, whether a write-back occurs and the line address of each write-back. A word-level reference checks the load data and the written-back line contents.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WB,
      ST_REFILL,
      ST_REPLAY,
      ST_STORE
   } wbc_state_e;
endpackage

// File: rtl/wbc_tag_match.sv
// Parallel tag compare: one comparator per way of the indexed set.
module wbc_tag_match #(
   parameter int WAYS  = 4,
   parameter int TAG_W = 5,
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
   input  logic [WAYS-1:0]            way_valid,
   input  logic [TAG_W-1:0]           look_tag,
   output logic                       hit,
   output logic [WAY_W-1:0]           hit_way
);
   logic [WAYS-1:0] match;

   for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign match[w] = way_valid[w] && (way_tag[w] == look_tag);
   end

   always_comb begin
      hit     = |match;
      hit_way = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (match[w]) hit_way = WAY_W'(w);
      end
   end
endmodule

// File: rtl/wbc_victim.sv
// Replacement choice: lowest invalid way first, else the LRU way.
module wbc_victim #(
   parameter int WAYS = 4,
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic [WAYS-1:0]  way_valid,
   input  logic [WAY_W-1:0] lru_way,
   output logic [WAY_W-1:0] victim_way
);
   always_comb begin
      victim_way = lru_way;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (!way_valid[w]) victim_way = WAY_W'(w);
      end
   end
endmodule

// File: rtl/wbc_lru.sv
// Recency state per set; variant chosen by the way count.
module wbc_lru #(
   parameter int WAYS = 4,
   parameter int SETS = 8,
   localparam int WAY_W = $clog2(WAYS),
   localparam int SET_W = $clog2(SETS)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             touch_en,
   input  logic [SET_W-1:0] touch_set,
   input  logic [WAY_W-1:0] touch_way,
   input  logic [SET_W-1:0] query_set,
   output logic [WAY_W-1:0] lru_way
);
   if (WAYS == 2) begin : g_bit
      logic [SETS-1:0] older_q;
      always_ff @(posedge clk) begin
         if (rst) older_q <= '0;
         else if (touch_en) older_q[touch_set] <= ~touch_way[0];
      end
      assign lru_way = older_q[query_set];
   end else begin : g_age
      // age 0 = most recent, WAYS-1 = oldest; ages in a set stay distinct
      logic [WAY_W-1:0] age_q [SETS][WAYS];
      logic [WAY_W-1:0] pivot;
      assign pivot = age_q[touch_set][touch_way];

      always_ff @(posedge clk) begin
         if (rst) begin
            for (int s = 0; s < SETS; s++)
               for (int w = 0; w < WAYS; w++)
                  age_q[s][w] <= WAY_W'(w);
         end else if (touch_en) begin
            for (int w = 0; w < WAYS; w++) begin
               if (WAY_W'(w) == touch_way) age_q[touch_set][w] <= '0;
               else if (age_q[touch_set][w] < pivot)
                  age_q[touch_set][w] <= age_q[touch_set][w] + 1'b1;
            end
         end
      end

      always_comb begin
         lru_way = '0;
         for (int w = 0; w < WAYS; w++) begin
            if (age_q[query_set][w] == WAY_W'(WAYS - 1)) lru_way = WAY_W'(w);
         end
      end
   end
endmodule

// File: rtl/wbc_top.sv
module wbc_top #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 32,
   parameter int WORDS  = 4,
   parameter int SETS   = 8,
   parameter int WAYS   = 4,
   localparam int OFF_W   = $clog2(WORDS),
   localparam int SET_W   = $clog2(SETS),
   localparam int WAY_W   = $clog2(WAYS),
   localparam int TAG_W   = ADDR_W - OFF_W - SET_W,
   localparam int LINE_W  = WORDS * DATA_W,
   localparam int LADDR_W = ADDR_W - OFF_W
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               cpu_req,
   input  logic               cpu_we,
   input  logic [ADDR_W-1:0]  cpu_addr,
   input  logic [DATA_W-1:0]  cpu_wdata,
   output logic [DATA_W-1:0]  cpu_rdata,
   output logic               cpu_stall,
   output logic               mem_req,
   output logic               mem_we,
   output logic [LADDR_W-1:0] mem_addr,
   output logic [LINE_W-1:0]  mem_wdata,
   input  logic [LINE_W-1:0]  mem_rdata,
   input  logic               mem_ack
);
   import wbc_pkg::*;

   if (WAYS != 2 && WAYS != 4) begin : g_bad_ways
      $error("wbc_top: WAYS must be 2 or 4");
   end
   if ((1 << OFF_W) != WORDS || WORDS < 2) begin : g_bad_words
      $error("wbc_top: WORDS must be a power of two, at least 2");
   end
   if ((1 << SET_W) != SETS || SETS < 2) begin : g_bad_sets
      $error("wbc_top: SETS must be a power of two, at least 2");
   end
   if (TAG_W < 1) begin : g_bad_addr
      $error("wbc_top: ADDR_W leaves no tag bits");
   end

   // address fields
   logic [OFF_W-1:0] off;
   logic [SET_W-1:0] idx;
   logic [TAG_W-1:0] tag;
   assign off = cpu_addr[OFF_W-1:0];
   assign idx = cpu_addr[OFF_W +: SET_W];
   assign tag = cpu_addr[ADDR_W-1 -: TAG_W];

   // storage
   logic [TAG_W-1:0]  tag_q   [SETS][WAYS];
   logic [LINE_W-1:0] data_q  [SETS][WAYS];
   logic [WAYS-1:0]   valid_q [SETS];
   logic [WAYS-1:0]   dirty_q [SETS];

   wbc_state_e       state_q;
   logic [WAY_W-1:0] way_q;

   // lookup
   logic [WAYS-1:0][TAG_W-1:0] set_tags;
   logic [WAYS-1:0]            set_valid;
   logic                       hit;
   logic [WAY_W-1:0]           hit_way;
   logic [WAY_W-1:0]           lru_way;
   logic [WAY_W-1:0]           victim_way;

   always_comb begin
      for (int w = 0; w < WAYS; w++) set_tags[w] = tag_q[idx][w];
      set_valid = valid_q[idx];
   end

   wbc_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
      .way_tag  (set_tags),
      .way_valid(set_valid),
      .look_tag (tag),
      .hit      (hit),
      .hit_way  (hit_way)
   );

   wbc_victim #(.WAYS(WAYS)) u_victim (
      .way_valid (set_valid),
      .lru_way   (lru_way),
      .victim_way(victim_way)
   );

   logic             touch_en;
   logic [WAY_W-1:0] touch_way;
   logic             idle_load_hit;
   logic             fill_done;
   logic             write_word;

   assign idle_load_hit = (state_q == ST_IDLE) && cpu_req && hit && !cpu_we;
   assign fill_done     = (state_q == ST_REFILL) && mem_ack;
   assign write_word    = (state_q == ST_STORE) || ((state_q == ST_REPLAY) && cpu_we);
   assign touch_en      = idle_load_hit || (state_q == ST_STORE) || fill_done;
   assign touch_way     = (state_q == ST_IDLE) ? hit_way : way_q;

   wbc_lru #(.WAYS(WAYS), .SETS(SETS)) u_lru (
      .clk      (clk),
      .rst      (rst),
      .touch_en (touch_en),
      .touch_set(idx),
      .touch_way(touch_way),
      .query_set(idx),
      .lru_way  (lru_way)
   );

   // processor side
   logic [WAY_W-1:0]  sel_way;
   logic [LINE_W-1:0] sel_line;
   assign sel_way   = (state_q == ST_IDLE) ? hit_way : way_q;
   assign sel_line  = data_q[idx][sel_way];
   assign cpu_rdata = sel_line[int'(off) * DATA_W +: DATA_W];
   assign cpu_stall = (state_q == ST_WB) || (state_q == ST_REFILL) ||
                      ((state_q == ST_IDLE) && cpu_req && !(hit && !cpu_we));

   // memory side
   assign mem_req   = (state_q == ST_WB) || (state_q == ST_REFILL);
   assign mem_we    = (state_q == ST_WB);
   assign mem_addr  = (state_q == ST_WB) ? {tag_q[idx][way_q], idx} : {tag, idx};
   assign mem_wdata = data_q[idx][way_q];

   // control and line state
   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_IDLE;
         way_q   <= '0;
         for (int s = 0; s < SETS; s++) begin
            valid_q[s] <= '0;
            dirty_q[s] <= '0;
         end
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (cpu_req) begin
                  if (hit) begin
                     way_q <= hit_way;
                     if (cpu_we) state_q <= ST_STORE;
                  end else begin
                     way_q   <= victim_way;
                     state_q <= (set_valid[victim_way] && dirty_q[idx][victim_way])
                                ? ST_WB : ST_REFILL;
                  end
               end
            end
            ST_WB: begin
               if (mem_ack) state_q <= ST_REFILL;
            end
            ST_REFILL: begin
               if (mem_ack) begin
                  valid_q[idx][way_q] <= 1'b1;
                  dirty_q[idx][way_q] <= 1'b0;
                  state_q             <= ST_REPLAY;
               end
            end
            ST_REPLAY: begin
               if (cpu_we) dirty_q[idx][way_q] <= 1'b1;
               state_q <= ST_IDLE;
            end
            ST_STORE: begin
               dirty_q[idx][way_q] <= 1'b1;
               state_q             <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // arrays without reset: tags and data are only read through a valid bit
   always_ff @(posedge clk) begin
      if (fill_done) begin
         data_q[idx][way_q] <= mem_rdata;
         tag_q[idx][way_q]  <= tag;
      end
      if (write_word) data_q[idx][way_q][int'(off) * DATA_W +: DATA_W] <= cpu_wdata;
   end
endmodule

// File: rtl/wbc_checker.sv
module wbc_checker #(
   parameter int LADDR_W = 8
) (
   input logic               clk,
   input logic               rst,
   input logic               cpu_req,
   input logic               cpu_we,
   input logic               cpu_stall,
   input logic               mem_req,
   input logic               mem_we,
   input logic [LADDR_W-1:0] mem_addr,
   input logic               mem_ack
);
   assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> !mem_req);

   assert_store_two_cycles_R3: assert property (@(posedge clk) disable iff (rst)
      (cpu_req && cpu_we && !cpu_stall) |-> $past(cpu_stall));

   assert_wb_before_refill_R6: assert property (@(posedge clk) disable iff (rst)
      (mem_req && mem_we && mem_ack) |=> (mem_req && !mem_we));

   assert_mem_held_R9: assert property (@(posedge clk) disable iff (rst)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

   assert_stall_during_miss_R9: assert property (@(posedge clk) disable iff (rst)
      mem_req |-> cpu_stall);
endmodule

bind wbc_top wbc_checker #(.LADDR_W(LADDR_W)) u_wbc_chk (
   .clk      (clk),
   .rst      (rst),
   .cpu_req  (cpu_req),
   .cpu_we   (cpu_we),
   .cpu_stall(cpu_stall),
   .mem_req  (mem_req),
   .mem_we   (mem_we),
   .mem_addr (mem_addr),
   .mem_ack  (mem_ack)
);

// File: tb/wbc_top_tb_top.sv
`timescale 1ns/1ps
module wbc_top_tb_top;
   localparam int ADDR_W  = 10;
   localparam int DATA_W  = 32;
   localparam int WORDS   = 4;
   localparam int SETS    = 8;
   localparam int WAYS    = 4;
   localparam int LINE_W  = WORDS * DATA_W;
   localparam int LADDR_W = ADDR_W - 2;
   localparam int NLINES  = 1 << LADDR_W;
   localparam int NWORDS  = 1 << ADDR_W;

   logic               clk = 1'b0;
   logic               rst = 1'b1;
   logic               cpu_req = 1'b0;
   logic               cpu_we = 1'b0;
   logic [ADDR_W-1:0]  cpu_addr = '0;
   logic [DATA_W-1:0]  cpu_wdata = '0;
   logic [DATA_W-1:0]  cpu_rdata;
   logic               cpu_stall;
   logic               mem_req;
   logic               mem_we;
   logic [LADDR_W-1:0] mem_addr;
   logic [LINE_W-1:0]  mem_wdata;
   logic [LINE_W-1:0]  mem_rdata = '0;
   logic               mem_ack = 1'b0;

   always #2.5 clk = ~clk;

   wbc_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS), .SETS(SETS), .WAYS(WAYS)) dut_i (
      .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .mem_ack(mem_ack)
   );

   int checks = 0;
   int fails  = 0;

   // backing memory and word-level reference
   logic [LINE_W-1:0] back_mem [NLINES];
   logic [DATA_W-1:0] ref_mem  [NWORDS];
   int wb_cnt, rf_cnt, wb_line, lat;

   function automatic logic [DATA_W-1:0] init_word(int a);
      return 32'h5A3C_0000 ^ DATA_W'(a * 40503);
   endfunction

   always @(posedge clk) begin
      mem_ack <= 1'b0;
      if (mem_req && !mem_ack) begin
         if (lat == 2) begin
            lat     <= 0;
            mem_ack <= 1'b1;
            if (mem_we) begin
               back_mem[mem_addr] <= mem_wdata;
               wb_cnt  = wb_cnt + 1;
               wb_line = int'(mem_addr);
            end else begin
               mem_rdata <= back_mem[mem_addr];
               rf_cnt = rf_cnt + 1;
            end
         end else lat <= lat + 1;
      end
   end

   // bench model of the cache directory
   int m_tag   [SETS][WAYS];
   bit m_val   [SETS][WAYS];
   bit m_dirty [SETS][WAYS];
   int m_age   [SETS][WAYS];

   function automatic void m_touch(int s, int way);
      int pv = m_age[s][way];
      for (int w = 0; w < WAYS; w++) begin
         if (w == way) m_age[s][w] = 0;
         else if (m_age[s][w] < pv) m_age[s][w] = m_age[s][w] + 1;
      end
   endfunction

   task automatic chk(bit ok, string req, longint act, longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   int last_rf, last_wb_line, last_stall;
   logic [DATA_W-1:0] last_rd;

   task automatic access(bit we, int addr, logic [DATA_W-1:0] wd);
      int s = (addr >> 2) % SETS;
      int tg = addr >> 5;
      bit hit = 0;
      int way = 0;
      bit exp_wb = 0;
      int exp_line = 0;
      int stalls = 0;
      for (int w = 0; w < WAYS; w++)
         if (m_val[s][w] && m_tag[s][w] == tg) begin hit = 1; way = w; end
      if (!hit) begin
         for (int w = 0; w < WAYS; w++) if (m_age[s][w] == WAYS - 1) way = w;
         for (int w = WAYS - 1; w >= 0; w--) if (!m_val[s][w]) way = w;
         exp_wb   = m_val[s][way] && m_dirty[s][way];
         exp_line = m_tag[s][way] * SETS + s;
         m_tag[s][way]   = tg;
         m_val[s][way]   = 1;
         m_dirty[s][way] = 0;
      end
      m_touch(s, way);
      if (we) m_dirty[s][way] = 1;

      @(negedge clk);
      wb_cnt = 0; rf_cnt = 0;
      cpu_req = 1'b1; cpu_we = we; cpu_addr = ADDR_W'(addr); cpu_wdata = wd;
      #0.1;
      while (cpu_stall && stalls < 100) begin
         stalls++;
         @(negedge clk);
      end
      chk(stalls < 100, "R9", stalls, 0);
      last_rd = cpu_rdata;
      @(posedge clk);
      #1 cpu_req = 1'b0;
      last_rf = rf_cnt; last_wb_line = wb_line; last_stall = stalls;

      if (hit) begin
         chk(rf_cnt == 0 && wb_cnt == 0, we ? "R3" : "R2", rf_cnt + wb_cnt, 0);
         chk(stalls == (we ? 1 : 0), we ? "R3" : "R2", stalls, we ? 1 : 0);
      end else begin
         chk(rf_cnt == 1, we ? "R8" : "R7", rf_cnt, 1);
         chk(wb_cnt == int'(exp_wb), exp_wb ? "R6" : "R7", wb_cnt, exp_wb);
         chk(stalls >= 2, "R9", stalls, 2);
         if (exp_wb && wb_cnt == 1) begin
            chk(wb_line == exp_line, "R5", wb_line, exp_line);
            for (int k = 0; k < WORDS; k++)
               chk(back_mem[exp_line][k*DATA_W +: DATA_W] == ref_mem[exp_line*WORDS + k],
                   "R6", back_mem[exp_line][k*DATA_W +: DATA_W], ref_mem[exp_line*WORDS + k]);
         end
      end
      if (!we) chk(last_rd == ref_mem[addr], hit ? "R2" : "R10", last_rd, ref_mem[addr]);
      else ref_mem[addr] = wd;
   endtask

   function automatic int mk_addr(int tg, int s, int o);
      return (tg << 5) | (s << 2) | o;
   endfunction

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog R9 actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin : main
      void'($urandom(32'd1234));
      wb_cnt = 0; rf_cnt = 0; wb_line = 0; lat = 0;
      for (int l = 0; l < NLINES; l++)
         for (int k = 0; k < WORDS; k++) begin
            back_mem[l][k*DATA_W +: DATA_W] = init_word(l * WORDS + k);
            ref_mem[l*WORDS + k] = init_word(l * WORDS + k);
         end
      for (int s = 0; s < SETS; s++)
         for (int w = 0; w < WAYS; w++) begin
            m_tag[s][w] = 0; m_val[s][w] = 0; m_dirty[s][w] = 0; m_age[s][w] = w;
         end

      repeat (4) @(posedge clk);
      #1 rst = 1'b0;
      @(negedge clk);
      chk(!cpu_stall, "R1", cpu_stall, 0);
      chk(!mem_req, "R1", mem_req, 0);

      // directed: fill set 2, all four lines must survive (R4)
      for (int t = 0; t < 4; t++) access(0, mk_addr(t, 2, t), '0);
      for (int t = 0; t < 4; t++) begin
         access(0, mk_addr(t, 2, 0), '0);
         chk(last_rf == 0, "R4", last_rf, 0);
      end
      // dirty tag 1, touch others, new tag evicts tag 1 (R5, R6)
      access(1, mk_addr(1, 2, 3), 32'hDEAD_BEEF);
      access(0, mk_addr(0, 2, 1), '0);
      access(0, mk_addr(2, 2, 1), '0);
      access(0, mk_addr(3, 2, 1), '0);
      access(0, mk_addr(4, 2, 0), '0);
      chk(last_wb_line == 1 * SETS + 2, "R5", last_wb_line, 1 * SETS + 2);
      // store miss then readback (R8)
      access(1, mk_addr(9, 5, 2), 32'h1234_5678);
      access(0, mk_addr(9, 5, 2), '0);
      chk(last_rd == 32'h1234_5678 && last_rf == 0, "R8", last_rd, 32'h1234_5678);
      // reload evicted dirty word (R10)
      access(0, mk_addr(1, 2, 3), '0);
      chk(last_rd == 32'hDEAD_BEEF, "R10", last_rd, 32'hDEAD_BEEF);

      // constrained random traffic
      for (int i = 0; i < 800; i++) begin
         int tg = int'($urandom % 6);
         int s  = int'($urandom % SETS);
         int o  = int'($urandom % WORDS);
         bit we = ($urandom % 10) < 4;
         access(we, mk_addr(tg, s, o), $urandom);
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule